// File: doc/BRIEF.md
# System Reference Pulse Generator

This block produces the system timing reference pulse that lines up the local multiframe clocks of several converters and the logic that talks to them. It runs on the octet clock. One local multiframe lasts F times K octet cycles, where F is the number of octets per frame and K the number of frames per multiframe. The reference period is n whole multiframes. Each pulse starts on a multiframe boundary and stays high for half the period, rounded down.

A two-bit mode input selects the behaviour. The output can be silenced entirely. It can run as a continuous square wave. It can send bursts of pulses separated by silent periods. It can also send a programmed number of pulses each time a request strobe is seen, and stay quiet otherwise. Mode and framing settings are taken up only at the end of a reference period, so a change can never shorten a pulse that has already started. A busy flag shows that a requested pulse sequence is pending or running.

Top module: `sysref_gen`

## Requirements
- R1: While reset is asserted, and until the internal reset release has completed, `sysref_o` and `busy_o` are low.
- R2: The reference period is F·K·n octet cycles, with a zero in any of `f_i`, `k_i` or `n_i` taken as one.
- R3: In every period that carries a pulse, `sysref_o` rises in the first cycle of the period, which is a multiframe boundary, and stays high for floor(period/2) cycles.
- R4: Mode 2'b00 (off) keeps `sysref_o` low.
- R5: Mode 2'b01 (continuous) puts a pulse in every period.
- R6: Mode 2'b10 (gapped) puts pulses in `burst_i` consecutive periods and then leaves `gap_i` periods silent, repeating. A burst count of zero gives silence, and a gap count of zero gives a continuous output.
- R7: In mode 2'b11 (one-shot), an accepted request starts pulses at the first period boundary at or after it. The pulses run for `cnt_i` consecutive periods, with zero taken as one, and the output then returns to low.
- R8: `busy_o` rises in the cycle after a request is accepted. It stays high until the period holding the last requested pulse has ended, and it falls only right after a period boundary.
- R9: A request that arrives while `busy_o` is high has no effect on the number of pulses produced.
- R10: Changes to mode, F, K or n take effect only at the next period boundary. A pulse that has started always runs its full width.
- R11: A request is accepted only while the active mode is one-shot. Requests made in other modes produce no pulses later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | 00 off, 01 continuous, 10 gapped, 11 one-shot |
| f_i | input | FW | Octets per frame |
| k_i | input | KW | Frames per multiframe |
| n_i | input | NW | Multiframes per reference period |
| burst_i | input | BW | Pulsed periods per burst in gapped mode |
| gap_i | input | BW | Silent periods between bursts in gapped mode |
| cnt_i | input | CW | Pulses per request in one-shot mode |
| req_i | input | 1 | One-shot request strobe |
| sysref_o | output | 1 | Reference pulse output |
| busy_o | output | 1 | One-shot sequence pending or running |

## Verification
The bench targets the places where an off-by-one or a missed case shows up directly on the output. A zero in a framing input must not stall the counters or give a zero-length period, and a faulty clamp would show as a lost or unbounded period. When the mode is switched off partway through a pulse, the pulse must run to full width; a design that applies settings at once would cut the pulse short. A request made while busy, or made outside one-shot mode, must add no pulses; a design that latches it would emit extra pulses later. Gapped runs with zero burst or zero gap counts check that the repeat count wraps correctly, where a bad wrap would stick the output high or low.

// File: rtl/sysref_gen_pkg.sv
package sysref_gen_pkg;

  typedef enum logic [1:0] {
    SRM_OFF     = 2'b00,
    SRM_CONT    = 2'b01,
    SRM_GAPPED  = 2'b10,
    SRM_ONESHOT = 2'b11
  } srm_e;

endpackage

// File: rtl/sysref_cfg_shadow.sv
module sysref_cfg_shadow
  import sysref_gen_pkg::*;
#(
  parameter int FW = 8,
  parameter int KW = 8,
  parameter int NW = 8,
  localparam int PW = FW + KW + NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  srm_e          mode_i,
  input  logic [FW-1:0] f_i,
  input  logic [KW-1:0] k_i,
  input  logic [NW-1:0] n_i,
  output srm_e          mode_q,
  output logic [FW-1:0] f_q,
  output logic [KW-1:0] k_q,
  output logic [NW-1:0] n_q,
  output logic [PW-1:0] plen_q,
  output logic [PW-1:0] half_q
);

  logic [FW-1:0] f_c;
  logic [KW-1:0] k_c;
  logic [NW-1:0] n_c;
  logic [PW-1:0] plen_new;
  srm_e          mode_d;
  logic [FW-1:0] f_d;
  logic [KW-1:0] k_d;
  logic [NW-1:0] n_d;
  logic [PW-1:0] plen_d;
  logic [PW-1:0] half_d;

  // zero in a framing field is taken as one
  always_comb begin
    f_c      = (f_i == '0) ? FW'(1) : f_i;
    k_c      = (k_i == '0) ? KW'(1) : k_i;
    n_c      = (n_i == '0) ? NW'(1) : n_i;
    plen_new = PW'(f_c) * PW'(k_c) * PW'(n_c);
  end

  always_comb begin
    mode_d = mode_q;
    f_d    = f_q;
    k_d    = k_q;
    n_d    = n_q;
    plen_d = plen_q;
    half_d = half_q;
    if (ld_i) begin
      mode_d = mode_i;
      f_d    = f_c;
      k_d    = k_c;
      n_d    = n_c;
      plen_d = plen_new;
      half_d = plen_new >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SRM_OFF;
      f_q    <= FW'(1);
      k_q    <= KW'(1);
      n_q    <= NW'(1);
      plen_q <= PW'(1);
      half_q <= '0;
    end else begin
      mode_q <= mode_d;
      f_q    <= f_d;
      k_q    <= k_d;
      n_q    <= n_d;
      plen_q <= plen_d;
      half_q <= half_d;
    end
  end

  AST_HALF_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    half_q < plen_q); // R3

endmodule

// File: rtl/sysref_phase_timer.sv
module sysref_phase_timer #(
  parameter int FW = 8,
  parameter int KW = 8,
  parameter int NW = 8,
  localparam int PW = FW + KW + NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] f_q,
  input  logic [KW-1:0] k_q,
  input  logic [NW-1:0] n_q,
  input  logic [PW-1:0] plen_q,
  output logic [PW-1:0] pcnt_o,
  output logic          mf_start_o,
  output logic          bnd_o
);

  logic [FW-1:0] oct_q, oct_d;
  logic [KW-1:0] frm_q, frm_d;
  logic [NW-1:0] mfi_q, mfi_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          oct_end, frm_end, mfi_end;

  always_comb begin
    oct_end    = (oct_q == f_q - FW'(1));
    frm_end    = (frm_q == k_q - KW'(1));
    mfi_end    = (mfi_q == n_q - NW'(1));
    bnd_o      = oct_end && frm_end && mfi_end;
    mf_start_o = (oct_q == '0) && (frm_q == '0);
    pcnt_o     = pcnt_q;
  end

  always_comb begin
    oct_d  = oct_q + FW'(1);
    frm_d  = frm_q;
    mfi_d  = mfi_q;
    pcnt_d = pcnt_q + PW'(1);
    if (bnd_o) begin
      oct_d  = '0;
      frm_d  = '0;
      mfi_d  = '0;
      pcnt_d = '0;
    end else if (oct_end) begin
      oct_d = '0;
      if (frm_end) begin
        frm_d = '0;
        mfi_d = mfi_q + NW'(1);
      end else begin
        frm_d = frm_q + KW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oct_q  <= '0;
      frm_q  <= '0;
      mfi_q  <= '0;
      pcnt_q <= '0;
    end else begin
      oct_q  <= oct_d;
      frm_q  <= frm_d;
      mfi_q  <= mfi_d;
      pcnt_q <= pcnt_d;
    end
  end

  AST_PCNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q < plen_q); // R2

  AST_BND_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_o |-> (pcnt_q == plen_q - PW'(1))); // R2

endmodule

// File: rtl/sysref_mode_seq.sv
module sysref_mode_seq
  import sysref_gen_pkg::*;
#(
  parameter int BW = 4,
  parameter int CW = 4,
  parameter int PW = 24,
  localparam int SW = BW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bnd_i,
  input  srm_e          mode_q_i,
  input  srm_e          mode_nx_i,
  input  logic [BW-1:0] burst_i,
  input  logic [BW-1:0] gap_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          req_i,
  input  logic [PW-1:0] pcnt_i,
  input  logic [PW-1:0] half_i,
  output logic          sysref_o,
  output logic          busy_o
);

  logic          act_q, act_d;
  logic [SW-1:0] gidx_q, gidx_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          pend_q, pend_d;
  logic          accept;
  logic [SW-1:0] tot, pos;
  logic [CW-1:0] cnt_c;

  always_comb begin
    busy_o   = pend_q || (rem_q != '0) || (act_q && (mode_q_i == SRM_ONESHOT));
    accept   = req_i && !busy_o && (mode_q_i == SRM_ONESHOT);
    sysref_o = act_q && (pcnt_i < half_i);
    tot      = SW'(burst_i) + SW'(gap_i);
    pos      = (mode_q_i == SRM_GAPPED) ? gidx_q : '0;
    cnt_c    = (cnt_i == '0) ? CW'(1) : cnt_i;
  end

  always_comb begin
    act_d  = act_q;
    gidx_d = gidx_q;
    rem_d  = rem_q;
    pend_d = pend_q;
    if (bnd_i) begin
      act_d  = 1'b0;
      gidx_d = '0;
      rem_d  = '0;
      pend_d = 1'b0;
      case (mode_nx_i)
        SRM_CONT: act_d = 1'b1;
        SRM_GAPPED: begin
          act_d  = pos < SW'(burst_i);
          gidx_d = (pos + SW'(1) >= tot) ? '0 : pos + SW'(1);
        end
        SRM_ONESHOT: begin
          if (mode_q_i == SRM_ONESHOT) begin
            if (rem_q != '0) begin
              act_d = 1'b1;
              rem_d = rem_q - CW'(1);
            end else if (pend_q || accept) begin
              act_d = 1'b1;
              rem_d = cnt_c - CW'(1);
            end
          end
        end
        default: act_d = 1'b0;
      endcase
    end else if (accept) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      gidx_q <= '0;
      rem_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      gidx_q <= gidx_d;
      rem_q  <= rem_d;
      pend_q <= pend_d;
    end
  end

  AST_BUSY_ENDS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(bnd_i)); // R8

  AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q_i == SRM_OFF) |-> !sysref_o); // R4

  AST_NO_TRUNCATED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysref_o) |-> (($past(pcnt_i) + PW'(1)) == $past(half_i))); // R10

endmodule

// File: rtl/sysref_gen.sv
module sysref_gen
  import sysref_gen_pkg::*;
#(
  parameter int FW = 8,
  parameter int KW = 8,
  parameter int NW = 8,
  parameter int BW = 4,
  parameter int CW = 4,
  localparam int PW = FW + KW + NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic [FW-1:0] f_i,
  input  logic [KW-1:0] k_i,
  input  logic [NW-1:0] n_i,
  input  logic [BW-1:0] burst_i,
  input  logic [BW-1:0] gap_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          req_i,
  output logic          sysref_o,
  output logic          busy_o
);

  logic          rs_meta, rs_n;
  srm_e          mode_in, mode_q;
  logic [FW-1:0] f_q;
  logic [KW-1:0] k_q;
  logic [NW-1:0] n_q;
  logic [PW-1:0] plen_q, half_q, pcnt;
  logic          mf_start, bnd;

  // asynchronous assertion, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign mode_in = srm_e'(mode_i);

  sysref_cfg_shadow #(.FW(FW), .KW(KW), .NW(NW)) u_cfg (
    .clk    (clk),
    .rst_n  (rs_n),
    .ld_i   (bnd),
    .mode_i (mode_in),
    .f_i    (f_i),
    .k_i    (k_i),
    .n_i    (n_i),
    .mode_q (mode_q),
    .f_q    (f_q),
    .k_q    (k_q),
    .n_q    (n_q),
    .plen_q (plen_q),
    .half_q (half_q)
  );

  sysref_phase_timer #(.FW(FW), .KW(KW), .NW(NW)) u_tmr (
    .clk        (clk),
    .rst_n      (rs_n),
    .f_q        (f_q),
    .k_q        (k_q),
    .n_q        (n_q),
    .plen_q     (plen_q),
    .pcnt_o     (pcnt),
    .mf_start_o (mf_start),
    .bnd_o      (bnd)
  );

  sysref_mode_seq #(.BW(BW), .CW(CW), .PW(PW)) u_seq (
    .clk       (clk),
    .rst_n     (rs_n),
    .bnd_i     (bnd),
    .mode_q_i  (mode_q),
    .mode_nx_i (mode_in),
    .burst_i   (burst_i),
    .gap_i     (gap_i),
    .cnt_i     (cnt_i),
    .req_i     (req_i),
    .pcnt_i    (pcnt),
    .half_i    (half_q),
    .sysref_o  (sysref_o),
    .busy_o    (busy_o)
  );

  AST_RISE_ON_MULTIFRAME: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(sysref_o) |-> mf_start); // R3

  AST_RISE_AT_PERIOD_START: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(sysref_o) |-> (pcnt == '0)); // R3

endmodule

// File: tb/tb_sysref_gen.sv
`timescale 1ns/1ps
module tb_sysref_gen;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic [7:0] f, k, n;
  logic [3:0] burst, gap, cnt;
  logic       req;
  logic       sysref_o, busy_o;

  int nchk, nerr, cyc;
  bit done;

  // reference model state
  int m_mode, m_len, m_pos, m_act, m_gi, m_rem, m_pend, m_sync;
  // output monitor
  int nrise, last_rise, rise_gap, hcnt, last_w;
  bit prev_s;

  sysref_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .f_i(f), .k_i(k), .n_i(n),
    .burst_i(burst), .gap_i(gap), .cnt_i(cnt), .req_i(req),
    .sysref_o(sysref_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int clamp1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit exp_busy();
    return (m_pend != 0) || (m_rem != 0) || (m_act != 0 && m_mode == 3);
  endfunction

  function automatic bit exp_sysref();
    return (m_act != 0) && (m_pos < m_len / 2);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_len = 1; m_pos = 0; m_act = 0; m_gi = 0; m_rem = 0; m_pend = 0;
  endtask

  task automatic model_edge();
    bit bnd, acc;
    int pos, tot;
    if (!rst_n) begin
      m_sync = 0;
      model_reset();
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bnd = (m_pos == m_len - 1);
      acc = req && !exp_busy() && (m_mode == 3);
      if (bnd) begin
        pos = (m_mode == 2) ? m_gi : 0;
        tot = int'(burst) + int'(gap);
        m_gi = 0;
        case (int'(mode))
          1: begin m_act = 1; m_rem = 0; m_pend = 0; end
          2: begin
            m_act = (pos < int'(burst)) ? 1 : 0;
            m_gi = (pos + 1 >= tot) ? 0 : pos + 1;
            m_rem = 0; m_pend = 0;
          end
          3: begin
            if (m_mode != 3) begin
              m_act = 0; m_rem = 0; m_pend = 0;
            end else if (m_rem != 0) begin
              m_act = 1; m_rem--;
            end else if (m_pend != 0 || acc) begin
              m_act = 1; m_rem = clamp1(int'(cnt)) - 1; m_pend = 0;
            end else begin
              m_act = 0;
            end
          end
          default: begin m_act = 0; m_rem = 0; m_pend = 0; end
        endcase
        m_mode = int'(mode);
        m_len = clamp1(int'(f)) * clamp1(int'(k)) * clamp1(int'(n));
        m_pos = 0;
      end else begin
        m_pos++;
        if (acc) m_pend = 1;
      end
    end
  endtask

  task automatic tick();
    string tg;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cyc++;
    case (m_mode)
      0: tg = "R4";
      1: tg = "R5";
      2: tg = "R6";
      default: tg = "R7";
    endcase
    chk(sysref_o == exp_sysref(), tg, int'(sysref_o), int'(exp_sysref()));
    chk(busy_o == exp_busy(), "R8", int'(busy_o), int'(exp_busy()));
    if (sysref_o && !prev_s) begin
      nrise++;
      rise_gap = cyc - last_rise;
      last_rise = cyc;
      hcnt = 1;
    end else if (sysref_o) begin
      hcnt++;
    end else if (prev_s) begin
      last_w = hcnt;
    end
    prev_s = sysref_o;
  endtask

  task automatic run(int c);
    for (int i = 0; i < c; i++) tick();
  endtask

  task automatic setcfg(int md, int ff, int kk, int nn);
    mode = 2'(md); f = 8'(ff); k = 8'(kk); n = 8'(nn);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240601));
    nchk = 0; nerr = 0; cyc = 0; done = 0;
    nrise = 0; last_rise = 0; rise_gap = 0; hcnt = 0; last_w = 0; prev_s = 0;
    m_sync = 0;
    model_reset();
    rst_n = 1'b0; req = 1'b0;
    setcfg(1, 1, 2, 1); burst = 4'd1; gap = 4'd1; cnt = 4'd1;

    // R1: quiet in reset and during reset release
    run(3);
    chk(sysref_o == 1'b0, "R1", int'(sysref_o), 0);
    chk(busy_o == 1'b0, "R1", int'(busy_o), 0);
    rst_n = 1'b1;
    tick();
    chk(sysref_o == 1'b0, "R1", int'(sysref_o), 0);
    chk(busy_o == 1'b0, "R1", int'(busy_o), 0);

    // R2 / R3: continuous, F=2 K=3 n=2 gives period 12 and width 6
    setcfg(1, 2, 3, 2);
    run(60);
    chk(rise_gap == 12, "R2", rise_gap, 12);
    chk(last_w == 6, "R3", last_w, 6);

    // R2: zero F clamps to one, K=3 n=1 gives period 3 and width 1
    setcfg(1, 0, 3, 1);
    run(30);
    chk(rise_gap == 3, "R2", rise_gap, 3);
    chk(last_w == 1, "R3", last_w, 1);

    // R6: gapped, burst 2 gap 1, period 2; 12 cycles hold 4 pulses
    setcfg(2, 1, 2, 1); burst = 4'd2; gap = 4'd1;
    run(20);
    nrise = 0;
    run(12);
    chk(nrise == 4, "R6", nrise, 4);
    // R6: burst zero silences
    burst = 4'd0; gap = 4'd2;
    run(10);
    nrise = 0;
    run(12);
    chk(nrise == 0, "R6", nrise, 0);

    // R10: switching off mid-pulse keeps full width (period 8, width 4)
    setcfg(1, 2, 4, 1);
    run(20);
    for (int i = 0; i < 20 && !sysref_o; i++) tick();
    tick();
    setcfg(0, 2, 4, 1);
    run(20);
    chk(last_w == 4, "R10", last_w, 4);
    chk(sysref_o == 1'b0, "R4", int'(sysref_o), 0);

    // R11: requests outside one-shot mode are dropped
    setcfg(0, 1, 2, 1); cnt = 4'd2;
    run(6);
    nrise = 0;
    for (int i = 0; i < 3; i++) begin req = 1'b1; tick(); req = 1'b0; tick(); end
    setcfg(3, 1, 2, 1);
    run(30);
    chk(nrise == 0, "R11", nrise, 0);

    // R9 / R8: second request while busy is ignored, count 2
    nrise = 0;
    req = 1'b1; tick(); req = 1'b0;
    chk(busy_o == 1'b1, "R8", int'(busy_o), 1);
    tick();
    req = 1'b1; tick(); req = 1'b0;
    run(20);
    chk(nrise == 2, "R9", nrise, 2);
    chk(busy_o == 1'b0, "R8", int'(busy_o), 0);

    // R7: count zero means one pulse
    cnt = 4'd0; nrise = 0;
    req = 1'b1; tick(); req = 1'b0;
    run(20);
    chk(nrise == 1, "R7", nrise, 1);

    // randomized phases, every cycle compared with the model
    for (int p = 0; p < 40; p++) begin
      mode  = 2'($urandom % 4);
      f     = 8'($urandom % 4);
      k     = 8'(1 + $urandom % 4);
      n     = 8'(1 + $urandom % 3);
      burst = 4'($urandom % 4);
      gap   = 4'($urandom % 3);
      cnt   = 4'($urandom % 4);
      for (int c = 0; c < 150; c++) begin
        req = (($urandom % 10) == 0);
        tick();
      end
      req = 1'b0;
    end

    finish_run();
  end

endmodule